// File: doc/BRIEF.md
# Debug Breakpoint Address Matcher

This block watches two streams of processor activity, data accesses and instruction fetches, and compares each one with four programmable breakpoint slots. Each slot holds an address, an access-kind code, a length code and an enable bit. The block reports which slots hit, one clock later, as a registered hit vector plus a combined hit flag. The exception logic then uses these outputs.

A data slot covers an aligned range of 1, 2 or 4 bytes. A data access hits the slot when any byte of the access falls inside that range, so an equality test on the start address alone would miss many hits. Two byte-wide slots placed side by side can cover an operand that is not aligned. In that case only bytes of the operand produce hits, and the bytes next to it do not. An instruction slot hits only on a fetch of the first byte of an instruction at exactly the slot address.

The slots are loaded through a simple write port. A write takes effect on the cycle after it is made.

Top module: `bpm_matcher`

## Requirements
- R1: After reset, `hit_vec` and `hit_any` are 0, and every slot is disabled, zero-filled and produces no hit.
- R2: The length code sets the slot's range size: 00 means 1 byte, 01 means 2 bytes and 11 means 4 bytes. The range starts at the slot address with its low 0, 1 or 2 bits cleared, according to that size.
- R3: A data access covers bytes `acc_addr` to `acc_addr + acc_size - 1`, with `acc_size` from 1 to 4. It hits a data slot when at least one of those bytes lies inside the slot's range. An `acc_size` of 0 or above 4 never hits.
- R4: Kind code 11 hits on data reads (`acc_write`=0) and on data writes (`acc_write`=1). Kind code 01 hits on data writes only.
- R5: Kind code 00 marks an instruction slot. It hits only when `fch_valid` and `fch_first` are both 1, `fch_addr` equals the slot address in all bits, and the length code is 00. Data accesses never hit an instruction slot, and fetches never hit a data slot.
- R6: Kind code 10, length code 10 and a cleared enable bit each prevent the slot from ever hitting.
- R7: Range comparisons use exact arithmetic with no wrap at the top of the address space. For example, an access reaching past address FFFFFFFF never hits a slot at address 0.
- R8: `hit_vec[i]` is the registered hit result of slot i for the inputs present at the previous rising edge. Bit i of `hit_vec` belongs to slot i. `hit_vec` is 0 after any cycle with neither strobe, and `hit_any` is the OR of `hit_vec`.
- R9: When `cfg_we` is 1, slot `cfg_sel` loads `cfg_addr`, `cfg_kind`, `cfg_len` and `cfg_en` at the rising edge. Accesses from the next cycle onward see the new values, while an access in the same cycle as the write sees the old values.
- R10: An access and a fetch presented in the same cycle are both evaluated, and their hits are ORed per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_sel | input | 2 | Index of the slot to write |
| cfg_addr | input | 32 | Slot address to load |
| cfg_kind | input | 2 | Access-kind code to load |
| cfg_len | input | 2 | Length code to load |
| cfg_en | input | 1 | Enable bit to load |
| acc_valid | input | 1 | Data access strobe |
| acc_addr | input | 32 | Lowest byte address of the access |
| acc_size | input | 3 | Byte count of the access, 1 to 4 |
| acc_write | input | 1 | 1 = write, 0 = read |
| fch_valid | input | 1 | Instruction fetch strobe |
| fch_addr | input | 32 | Fetch byte address |
| fch_first | input | 1 | Fetch is the first byte of an instruction |
| hit_vec | output | 4 | Registered per-slot hit bits |
| hit_any | output | 1 | Registered OR of all slot hits |

## Verification
On every cycle, the assertions check the following: a hit always follows a strobe in the previous cycle, and a slot that was disabled, or carried kind 10 or length 10, never hits. A write-only slot hits only after a data write, an instruction slot hits only after a first-byte fetch, and `hit_any` always agrees with the vector. Whether a hit is correct, and not merely allowed, can only be shown by the bench's scenarios. These scenarios compare results against a byte-by-byte overlap model. They include the partial overlaps around 2-byte and 4-byte ranges, unaligned operands split across two slots, accesses at the top of the address space, and writes to a slot in the same cycle as an access that uses it.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 3;

    typedef enum logic [1:0] {
        KIND_EXEC  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_NONE  = 2'b10,
        KIND_RDWR  = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        SPAN_1   = 2'b00,
        SPAN_2   = 2'b01,
        SPAN_BAD = 2'b10,
        SPAN_4   = 2'b11
    } span_e;

    typedef struct packed {
        logic              en;
        kind_e             kind;
        span_e             span;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    // Number of bytes covered by a length code (0 for the undefined code)
    function automatic logic [2:0] span_bytes(span_e s);
        case (s)
            SPAN_1:  return 3'd1;
            SPAN_2:  return 3'd2;
            SPAN_4:  return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    // Address with the bits inside the covered span cleared
    function automatic logic [ADDR_W-1:0] span_base(logic [ADDR_W-1:0] a, span_e s);
        logic [ADDR_W-1:0] m;
        case (s)
            SPAN_2:  m = {{(ADDR_W-1){1'b1}}, 1'b0};
            SPAN_4:  m = {{(ADDR_W-2){1'b1}}, 2'b00};
            default: m = '1;
        endcase
        return a & m;
    endfunction

endpackage

// File: rtl/bpm_slot_regs.sv
module bpm_slot_regs
    import bpm_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [1:0]              kind,
    input  logic [1:0]              len,
    input  logic                    en,
    output slot_t [NSLOT-1:0]       slots
);

    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slots[i] <= '{en: 1'b0, kind: KIND_EXEC, span: SPAN_1, addr: '0};
            end else if (we && (sel == SEL_W'(i))) begin
                slots[i] <= '{en: en, kind: kind_e'(kind), span: span_e'(len), addr: addr};
            end
        end
    end

endmodule

// File: rtl/bpm_data_cmp.sv
module bpm_data_cmp
    import bpm_pkg::*;
(
    input  slot_t              slot,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SIZE_W-1:0]  size,
    input  logic               write,
    output logic               hit
);

    logic [ADDR_W:0] lo_slot, hi_slot, lo_acc, hi_acc;
    logic [2:0]      nbytes;
    logic            kind_ok, size_ok, overlap;

    always_comb begin
        nbytes  = span_bytes(slot.span);
        lo_slot = {1'b0, span_base(slot.addr, slot.span)};
        hi_slot = lo_slot + (ADDR_W+1)'(nbytes);    // exclusive end, 33-bit: no wrap
        lo_acc  = {1'b0, addr};
        hi_acc  = lo_acc + (ADDR_W+1)'(size);
        size_ok = (size != '0) && (size <= SIZE_W'(4));
        overlap = (lo_acc < hi_slot) && (lo_slot < hi_acc);
        unique case (slot.kind)
            KIND_RDWR:  kind_ok = 1'b1;
            KIND_WRITE: kind_ok = write;
            default:    kind_ok = 1'b0;
        endcase
        hit = valid && slot.en && kind_ok && size_ok && (nbytes != 3'd0) && overlap;
    end

endmodule

// File: rtl/bpm_fetch_cmp.sv
module bpm_fetch_cmp
    import bpm_pkg::*;
(
    input  slot_t              slot,
    input  logic               valid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               first,
    output logic               hit
);

    always_comb begin
        hit = valid && first && slot.en
           && (slot.kind == KIND_EXEC)
           && (slot.span == SPAN_1)
           && (addr == slot.addr);
    end

endmodule

// File: rtl/bpm_matcher.sv
module bpm_matcher
    import bpm_pkg::*;
#(
    parameter int NSLOT = 4,
    localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [SEL_W-1:0]      cfg_sel,
    input  logic [ADDR_W-1:0]     cfg_addr,
    input  logic [1:0]            cfg_kind,
    input  logic [1:0]            cfg_len,
    input  logic                  cfg_en,
    input  logic                  acc_valid,
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic [SIZE_W-1:0]     acc_size,
    input  logic                  acc_write,
    input  logic                  fch_valid,
    input  logic [ADDR_W-1:0]     fch_addr,
    input  logic                  fch_first,
    output logic [NSLOT-1:0]      hit_vec,
    output logic                  hit_any
);

    slot_t [NSLOT-1:0] slots;
    logic  [NSLOT-1:0] d_hit, f_hit, hit_next;

    bpm_slot_regs #(.NSLOT(NSLOT)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .addr  (cfg_addr),
        .kind  (cfg_kind),
        .len   (cfg_len),
        .en    (cfg_en),
        .slots (slots)
    );

    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
        bpm_data_cmp u_dcmp (
            .slot  (slots[i]),
            .valid (acc_valid),
            .addr  (acc_addr),
            .size  (acc_size),
            .write (acc_write),
            .hit   (d_hit[i])
        );
        bpm_fetch_cmp u_fcmp (
            .slot  (slots[i]),
            .valid (fch_valid),
            .addr  (fch_addr),
            .first (fch_first),
            .hit   (f_hit[i])
        );
    end

    assign hit_next = d_hit | f_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_vec <= '0;
            hit_any <= 1'b0;
        end else begin
            hit_vec <= hit_next;
            hit_any <= |hit_next;
        end
    end

    // R8: the combined flag register agrees with the vector register
    p_any_matches_vec_r8: assert property (@(posedge clk) disable iff (rst)
        hit_any == (hit_vec != '0));

    // R8: no strobe in the previous cycle means no hit now
    p_no_strobe_no_hit_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(acc_valid || fch_valid) |-> (hit_vec == '0));

    for (genvar i = 0; i < NSLOT; i++) begin : g_chk
        // R6: a disabled, kind-10 or length-10 slot stays quiet
        p_quiet_slot_r6: assert property (@(posedge clk) disable iff (rst)
            hit_vec[i] |-> ($past(slots[i].en) && $past(slots[i].kind) != KIND_NONE
                            && $past(slots[i].span) != SPAN_BAD));
        // R4: a write-only slot needs a data write
        p_write_only_r4: assert property (@(posedge clk) disable iff (rst)
            (hit_vec[i] && $past(slots[i].kind) == KIND_WRITE) |-> $past(acc_valid && acc_write));
        // R5: an instruction slot needs a first-byte fetch at a 1-byte length code
        p_exec_fetch_r5: assert property (@(posedge clk) disable iff (rst)
            (hit_vec[i] && $past(slots[i].kind) == KIND_EXEC)
              |-> $past(fch_valid && fch_first && slots[i].span == SPAN_1));
    end

endmodule

// File: tb/tb_bpm_matcher.sv
`timescale 1ns/1ps
module tb_bpm_matcher;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_sel;
    logic [31:0] cfg_addr;
    logic [1:0]  cfg_kind;
    logic [1:0]  cfg_len;
    logic        cfg_en;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [2:0]  acc_size;
    logic        acc_write;
    logic        fch_valid;
    logic [31:0] fch_addr;
    logic        fch_first;
    logic [3:0]  hit_vec;
    logic        hit_any;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // model copy of the slot contents, kept from the writes the bench makes
    logic [31:0] m_addr [4];
    logic [1:0]  m_kind [4];
    logic [1:0]  m_len  [4];
    logic        m_en   [4];

    always #4 clk = ~clk;   // 125 MHz

    bpm_matcher dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_addr(cfg_addr),
        .cfg_kind(cfg_kind), .cfg_len(cfg_len), .cfg_en(cfg_en),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
        .fch_valid(fch_valid), .fch_addr(fch_addr), .fch_first(fch_first),
        .hit_vec(hit_vec), .hit_any(hit_any)
    );

    // Expected data hit, byte by byte (R2, R3, R4, R6, R7)
    function automatic bit exp_data(int s, logic [31:0] a, logic [2:0] sz, logic wr);
        longint n, base, b;
        if (!m_en[s]) return 0;
        if (m_kind[s] == 2'b01 && !wr) return 0;
        if (m_kind[s] != 2'b11 && m_kind[s] != 2'b01) return 0;
        case (m_len[s])
            2'b00: n = 1;
            2'b01: n = 2;
            2'b11: n = 4;
            default: return 0;
        endcase
        if (sz < 1 || sz > 4) return 0;
        base = longint'(m_addr[s]) - (longint'(m_addr[s]) % n);
        for (int k = 0; k < int'(sz); k++) begin
            b = longint'(a) + k;
            if (b >= base && b < base + n) return 1;
        end
        return 0;
    endfunction

    // Expected fetch hit (R5, R6)
    function automatic bit exp_fetch(int s, logic [31:0] a, logic first);
        return m_en[s] && m_kind[s] == 2'b00 && m_len[s] == 2'b00 && first && a == m_addr[s];
    endfunction

    task automatic idle_inputs();
        cfg_we = 0; cfg_sel = 0; cfg_addr = 0; cfg_kind = 0; cfg_len = 0; cfg_en = 0;
        acc_valid = 0; acc_addr = 0; acc_size = 0; acc_write = 0;
        fch_valid = 0; fch_addr = 0; fch_first = 0;
    endtask

    task automatic write_slot(int s, logic [31:0] a, logic [1:0] k, logic [1:0] l, logic e);
        @(negedge clk);
        idle_inputs();
        cfg_we = 1; cfg_sel = 2'(s); cfg_addr = a; cfg_kind = k; cfg_len = l; cfg_en = e;
        @(negedge clk);
        cfg_we = 0;
        m_addr[s] = a; m_kind[s] = k; m_len[s] = l; m_en[s] = e;
    endtask

    task automatic compare(logic [3:0] expv, string tag);
        checks++;
        if (hit_vec !== expv || hit_any !== (expv != 0)) begin
            failures++;
            $display("FAIL %s: hit_vec=%b hit_any=%b expected hit_vec=%b hit_any=%b",
                     tag, hit_vec, hit_any, expv, expv != 0);
        end
    endtask

    // One cycle of stimulus; result checked after the capturing edge
    task automatic apply(logic av, logic [31:0] aa, logic [2:0] asz, logic aw,
                         logic fv, logic [31:0] fa, logic ff, string tag);
        logic [3:0] e;
        @(negedge clk);
        idle_inputs();
        acc_valid = av; acc_addr = aa; acc_size = asz; acc_write = aw;
        fch_valid = fv; fch_addr = fa; fch_first = ff;
        for (int s = 0; s < 4; s++)
            e[s] = (av && exp_data(s, aa, asz, aw)) || (fv && exp_fetch(s, fa, ff));
        @(posedge clk);
        #1;
        compare(e, tag);
    endtask

    task automatic acc(logic [31:0] a, logic [2:0] sz, logic wr, string tag);
        apply(1, a, sz, wr, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] e;
        void'($urandom(32'h5eed_1234));
        idle_inputs();
        for (int s = 0; s < 4; s++) begin
            m_addr[s] = 0; m_kind[s] = 0; m_len[s] = 0; m_en[s] = 0;
        end
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        compare(4'b0000, "R1 reset outputs");
        @(negedge clk);
        rst = 0;
        // R1: reset slots are disabled: fetch at 0 with first byte hits nothing
        apply(0, 0, 0, 0, 1, 32'h0, 1, "R1 reset slots disabled");
        apply(1, 32'h0, 3'd4, 1, 0, 0, 0, "R1 reset slots no data hit");

        // Example setup
        write_slot(0, 32'h000A_0001, 2'b11, 2'b00, 1);
        write_slot(1, 32'h000A_0002, 2'b01, 2'b00, 1);
        write_slot(2, 32'h000B_0002, 2'b11, 2'b01, 1);
        write_slot(3, 32'h000C_0000, 2'b01, 2'b11, 1);
        acc(32'h000A_0001, 3'd1, 0, "R4 rdwr read 1 byte");
        acc(32'h000A_0001, 3'd2, 1, "R3 2-byte write spans two slots");
        acc(32'h000A_0002, 3'd2, 0, "R4 write-only slot ignores read");
        acc(32'h000B_0001, 3'd4, 0, "R3 4-byte read below 2-byte range");
        acc(32'h000B_0003, 3'd1, 0, "R2 upper byte of 2-byte range");
        acc(32'h000B_0004, 3'd1, 1, "R3 byte just above range");
        acc(32'h000B_0000, 3'd2, 1, "R3 bytes just below range");
        acc(32'h000C_0003, 3'd1, 1, "R2 top byte of 4-byte range");
        acc(32'h000C_0000, 3'd4, 0, "R4 read ignored by write-only");
        acc(32'h000B_FFFE, 3'd4, 1, "R3 access crossing into 4-byte slot area");
        acc(32'h000C_0001, 3'd0, 1, "R3 size 0 no hit");
        acc(32'h000C_0001, 3'd5, 1, "R3 size 5 no hit");
        acc(32'h000C_0002, 3'd4, 1, "R3 access ending past 4-byte boundary");

        // R2: unaligned slot address has low bits masked
        write_slot(2, 32'h0000_1003, 2'b11, 2'b11, 1);
        acc(32'h0000_1000, 3'd1, 0, "R2 masked base low byte");
        acc(32'h0000_1004, 3'd1, 0, "R2 byte past masked range");

        // Unaligned operand covered by two byte slots
        write_slot(0, 32'h0000_2003, 2'b11, 2'b00, 1);
        write_slot(1, 32'h0000_2004, 2'b01, 2'b00, 1);
        acc(32'h0000_2003, 3'd2, 1, "R3 split operand both slots");
        acc(32'h0000_2002, 3'd1, 1, "R3 neighbour byte below operand");
        acc(32'h0000_2005, 3'd2, 1, "R3 neighbour bytes above operand");

        // R6: undefined codes and enable
        write_slot(0, 32'h0000_3000, 2'b10, 2'b00, 1);
        write_slot(1, 32'h0000_3000, 2'b11, 2'b10, 1);
        write_slot(2, 32'h0000_3000, 2'b11, 2'b11, 0);
        write_slot(3, 32'h0000_3000, 2'b11, 2'b11, 1);
        acc(32'h0000_3000, 3'd4, 1, "R6 kind 10 len 10 disabled silent");

        // R7: top of address space
        write_slot(0, 32'h0000_0000, 2'b11, 2'b11, 1);
        write_slot(3, 32'hFFFF_FFFC, 2'b11, 2'b11, 1);
        acc(32'hFFFF_FFFE, 3'd4, 0, "R7 no wrap to address 0");
        acc(32'hFFFF_FFFF, 3'd1, 1, "R7 last byte hits top slot");

        // R5: instruction slots
        write_slot(0, 32'h0040_0010, 2'b00, 2'b00, 1);
        write_slot(1, 32'h0040_0010, 2'b00, 2'b11, 1);
        write_slot(2, 32'h0040_0010, 2'b11, 2'b00, 1);
        write_slot(3, 32'h0040_0011, 2'b00, 2'b00, 1);
        apply(0, 0, 0, 0, 1, 32'h0040_0010, 1, "R5 fetch first byte hit");
        apply(0, 0, 0, 0, 1, 32'h0040_0010, 0, "R5 non-first fetch no hit");
        apply(0, 0, 0, 0, 1, 32'h0040_0011, 1, "R5 exact address only");
        apply(1, 32'h0040_0010, 3'd1, 1, 0, 0, 0, "R5 data access ignores exec slot");
        // R10: both strobes in one cycle
        apply(1, 32'h0040_0010, 3'd1, 0, 1, 32'h0040_0011, 1, "R10 access and fetch together");

        // R8: no strobe -> zero
        apply(0, 32'h0040_0010, 3'd1, 1, 0, 32'h0040_0010, 1, "R8 no strobe no hit");

        // R9: write in same cycle as access sees old value
        @(negedge clk);
        idle_inputs();
        cfg_we = 1; cfg_sel = 2'd2; cfg_addr = 32'h0050_0000; cfg_kind = 2'b11; cfg_len = 2'b00; cfg_en = 1;
        acc_valid = 1; acc_addr = 32'h0050_0000; acc_size = 3'd1; acc_write = 1;
        e = 0;
        for (int s = 0; s < 4; s++) e[s] = exp_data(s, 32'h0050_0000, 3'd1, 1);
        @(posedge clk);
        #1;
        compare(e, "R9 same-cycle access sees old slot");
        m_addr[2] = 32'h0050_0000; m_kind[2] = 2'b11; m_len[2] = 2'b00; m_en[2] = 1;
        acc(32'h0050_0000, 3'd1, 1, "R9 next access sees new slot");

        // Random phase
        for (int it = 0; it < 400; it++) begin
            logic [31:0] region;
            region = ($urandom % 4 == 0) ? 32'hFFFF_FFF0 : 32'h0060_0000;
            if (it % 20 == 0) begin
                for (int s = 0; s < 4; s++)
                    write_slot(s, region + ($urandom % 16), 2'($urandom), 2'($urandom),
                               1'($urandom % 5 != 0));
            end
            apply(1'($urandom % 4 != 0), region + ($urandom % 20), 3'($urandom % 6),
                  1'($urandom), 1'($urandom % 2), region + ($urandom % 16), 1'($urandom),
                  "R3 random access/fetch mix");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule